// File: doc/BRIEF.md
# Flash Access Error Detector

The detector sits beside the flash controller. Every cycle it checks the three kinds of flash access against a set of rules: a program-store write or erase, a data read, and an instruction fetch or branch target. An access breaks a rule when its address lies strictly above a programmable boundary, the lock address. It also breaks a rule when the security logic denies that kind of access. A write or erase also breaks a rule when the supply monitor is not running at its high threshold.

When any access breaks a rule, the block suppresses the offending write in the same cycle. On the next clock edge it raises a system reset request and sets a sticky error flag. The external reset pin is never driven. The flag tells software after the restart that a flash fault caused the reset. A power-on reset clears the flag, and so does a later reset from any other source, reported on a strobe.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released, `err_rst_o` and `err_flag_o` are 0. Asserting `rst_n` clears a set flag at once.
- R2: A write attempt is `wr_req_i` high together with `store_wr_en_i` high. A write attempt whose `addr_i` is greater than `lock_addr_i` makes `err_rst_o` high on the next clock edge.
- R3: A write attempt is illegal when `supmon_on_i` is 0, or when `supmon_high_i` is 0, whatever its address.
- R4: A data read (`rd_req_i`) whose address is greater than `lock_addr_i` is illegal.
- R5: An instruction fetch (`fetch_req_i`) whose address is greater than `lock_addr_i` is illegal.
- R6: An address equal to `lock_addr_i`, or below it, is legal for every access kind.
- R7: `sec_deny_i` makes an access of the matching kind illegal at any address. Bit 0 applies to writes, bit 1 to data reads and bit 2 to fetches.
- R8: `wr_commit_o` is high in the same cycle as a legal write attempt. It is low for an illegal write attempt and whenever no write attempt is present.
- R9: `wr_req_i` with `store_wr_en_i` at 0 is not a flash write. It is not checked, it is not committed, and it raises no error.
- R10: `err_flag_o` is set on the edge after an illegal access and holds through legal cycles. A high `other_rst_i` clears it on the next edge, except when an illegal access occurs in that same cycle; then the flag stays set.
- R11: `err_rst_o` on each edge equals whether the cycle before that edge held an illegal access. It is 0 after a legal or idle cycle.
- R12: The supply monitor inputs have no effect on data reads or fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert, synchronized release |
| wr_req_i | input | 1 | Write or erase strobe |
| store_wr_en_i | input | 1 | Program-store write enable |
| rd_req_i | input | 1 | Data read strobe |
| fetch_req_i | input | 1 | Instruction fetch or branch strobe |
| addr_i | input | ADDR_W | Access address |
| lock_addr_i | input | ADDR_W | Highest legal address |
| supmon_on_i | input | 1 | Supply monitor enabled |
| supmon_high_i | input | 1 | Supply monitor at high threshold |
| sec_deny_i | input | 3 | Security denial per kind: bit 0 write, bit 1 read, bit 2 fetch |
| other_rst_i | input | 1 | A reset from a different source occurred |
| wr_commit_o | output | 1 | Write may proceed this cycle |
| err_rst_o | output | 1 | Registered reset request |
| err_flag_o | output | 1 | Sticky flash-error flag |

## Verification
`wr_commit_o` is combinational. The bench drives inputs at the falling edge and checks this output a short delay later, in the same cycle. `err_rst_o` and `err_flag_o` are due one rising edge after the stimulus. The bench therefore checks them at the following falling edge, before it applies the next stimulus, against a model updated once per cycle. Reset release passes through a two-stage synchronizer, so the first stimulus waits three cycles.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  localparam int unsigned N_KIND = 3;

  typedef struct packed {
    logic fetch;
    logic read;
    logic write;
  } kind_vec_t;
endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fg_bound_cmp.sv
module fg_bound_cmp #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] bound_i,
  output logic              above_o
);
  // Equal to the bound counts as inside the user space.
  assign above_o = (addr_i > bound_i);
endmodule

// File: rtl/fg_access_check.sv
module fg_access_check
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  kind_vec_t         strobe_i,
  input  kind_vec_t         deny_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lock_addr_i,
  input  logic              supply_ok_i,
  output kind_vec_t         viol_o,
  output logic              any_viol_o
);
  logic              above;
  logic [N_KIND-1:0] strobe_v, deny_v, viol_v;

  fg_bound_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr_i  (addr_i),
    .bound_i (lock_addr_i),
    .above_o (above)
  );

  assign strobe_v = strobe_i;
  assign deny_v   = deny_i;

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    if (k == int'(KIND_WRITE)) begin : g_wr
      assign viol_v[k] = strobe_v[k] & (above | deny_v[k] | ~supply_ok_i);
    end else begin : g_rd
      assign viol_v[k] = strobe_v[k] & (above | deny_v[k]);
    end
  end

  assign viol_o     = viol_v;
  assign any_viol_o = |viol_v;
endmodule

// File: rtl/fg_err_state.sv
module fg_err_state (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_i,
  input  logic clr_i,
  output logic err_rst_o,
  output logic err_flag_o
);
  logic req_q, req_d;
  logic flag_q, flag_d;

  always_comb begin
    req_d  = viol_i;
    flag_d = flag_q;
    if (clr_i)  flag_d = 1'b0;
    if (viol_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      flag_q <= flag_d;
    end
  end

  assign err_rst_o  = req_q;
  assign err_flag_o = flag_q;

  // R10: the flag holds unless a clear arrives
  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R10: a request always comes with the flag set
  a_r10_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> flag_q);
  // R10: a clear without a new violation empties the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !viol_i) |=> !flag_q);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req_i,
  input  logic              store_wr_en_i,
  input  logic              rd_req_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lock_addr_i,
  input  logic              supmon_on_i,
  input  logic              supmon_high_i,
  input  logic [2:0]        sec_deny_i,
  input  logic              other_rst_i,
  output logic              wr_commit_o,
  output logic              err_rst_o,
  output logic              err_flag_o
);
  logic      rst_n_s;
  logic      supply_ok;
  logic      any_viol;
  kind_vec_t strobe, deny, viol;

  fg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign supply_ok    = supmon_on_i & supmon_high_i;
  assign strobe.write = wr_req_i & store_wr_en_i;
  assign strobe.read  = rd_req_i;
  assign strobe.fetch = fetch_req_i;
  assign deny.write   = sec_deny_i[0];
  assign deny.read    = sec_deny_i[1];
  assign deny.fetch   = sec_deny_i[2];

  fg_access_check #(.ADDR_W(ADDR_W)) u_check (
    .strobe_i    (strobe),
    .deny_i      (deny),
    .addr_i      (addr_i),
    .lock_addr_i (lock_addr_i),
    .supply_ok_i (supply_ok),
    .viol_o      (viol),
    .any_viol_o  (any_viol)
  );

  assign wr_commit_o = strobe.write & ~viol.write;

  fg_err_state u_state (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .viol_i     (any_viol),
    .clr_i      (other_rst_i),
    .err_rst_o  (err_rst_o),
    .err_flag_o (err_flag_o)
  );

  // R11: a violation is followed by a request on the next edge
  a_r11_req_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    any_viol |=> err_rst_o);
  // R11: a clean cycle leaves no request
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n_s)
    !any_viol |=> !err_rst_o);
  // R8: a committed write is never one the checker flagged
  a_r8_commit_legal: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_commit_o |-> !viol.write);
  // R6: a clean read exactly at the boundary is legal
  a_r6_equal_legal: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_req_i && !fetch_req_i && !strobe.write && addr_i == lock_addr_i && !sec_deny_i[1])
      |-> !any_viol);
  // R9: a write strobe without enable never commits
  a_r9_no_enable: assert property (@(posedge clk) disable iff (!rst_n_s)
    !store_wr_en_i |-> !wr_commit_o);
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  localparam int unsigned ADDR_W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic wr, swe, rd, ft, mon_on, mon_hi, oth;
  logic [ADDR_W-1:0] addr, lock;
  logic [2:0] sec;
  logic commit, err_rst, err_flag;

  int checks = 0;
  int errors = 0;
  logic model_flag;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req_i(wr), .store_wr_en_i(swe),
    .rd_req_i(rd), .fetch_req_i(ft), .addr_i(addr), .lock_addr_i(lock),
    .supmon_on_i(mon_on), .supmon_high_i(mon_hi), .sec_deny_i(sec),
    .other_rst_i(oth), .wr_commit_o(commit), .err_rst_o(err_rst),
    .err_flag_o(err_flag)
  );

  function automatic logic wr_bad();
    return (addr > lock) | sec[0] | ~(mon_on & mon_hi);
  endfunction

  function automatic logic exp_illegal();
    logic w;
    w = wr & swe;
    return (w & wr_bad()) | (rd & ((addr > lock) | sec[1])) | (ft & ((addr > lock) | sec[2]));
  endfunction

  function automatic logic exp_commit();
    return wr & swe & ~wr_bad();
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr = 0; swe = 0; rd = 0; ft = 0; sec = 3'b000; oth = 0;
    mon_on = 1; mon_hi = 1;
  endtask

  // Inputs already set at a falling edge; checks commit now, registered results one edge later.
  task automatic cycle(input string tag);
    logic ill;
    #1;
    ill = exp_illegal();
    chk({tag, " R8 commit"}, commit, exp_commit());
    @(posedge clk);
    model_flag = ill ? 1'b1 : (oth ? 1'b0 : model_flag);
    @(negedge clk);
    chk({tag, " R11 request"}, err_rst, ill);
    chk({tag, " R10 flag"}, err_flag, model_flag);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    idle();
    addr = '0; lock = 16'h3FFF;
    rst_n = 0;
    model_flag = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset request", err_rst, 1'b0);
    chk("R1 reset flag", err_flag, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after release flag", err_flag, 1'b0);

    // R2 write above lock
    wr = 1; swe = 1; addr = 16'h4000; cycle("R2 above");
    // R6 write at lock legal; flag stays (R10 sticky)
    wr = 1; swe = 1; addr = 16'h3FFF; cycle("R6 equal write");
    rd = 1; addr = 16'h3FFF; cycle("R6 equal read");
    ft = 1; addr = 16'h3FFE; cycle("R6 below fetch");
    // R10 clear by other reset
    oth = 1; cycle("R10 clear");
    // R3 supply monitor off / low threshold
    wr = 1; swe = 1; addr = 16'h0100; mon_on = 0; cycle("R3 monitor off");
    wr = 1; swe = 1; addr = 16'h0100; mon_hi = 0; cycle("R3 low threshold");
    // R10 clear and violation together: set wins
    oth = 1; rd = 1; addr = 16'h8000; cycle("R10 set wins");
    oth = 1; cycle("R10 clear2");
    // R4, R5
    rd = 1; addr = 16'h4001; cycle("R4 read above");
    oth = 1; cycle("R10 clear3");
    ft = 1; addr = 16'hFFFF; cycle("R5 fetch above");
    oth = 1; cycle("R10 clear4");
    // R7 security per kind
    wr = 1; swe = 1; addr = 16'h0010; sec = 3'b001; cycle("R7 write deny");
    rd = 1; addr = 16'h0010; sec = 3'b010; cycle("R7 read deny");
    ft = 1; addr = 16'h0010; sec = 3'b100; cycle("R7 fetch deny");
    rd = 1; addr = 16'h0010; sec = 3'b101; oth = 1; cycle("R7 other-kind deny ignored");
    // R9 write strobe without enable, bad address and monitor off
    wr = 1; swe = 0; addr = 16'hF000; mon_on = 0; cycle("R9 no enable");
    // R12 monitor off does not affect reads/fetches
    rd = 1; ft = 1; addr = 16'h0200; mon_on = 0; mon_hi = 0; cycle("R12 monitor ignored");
    // R1 mid-run reset clears the flag
    wr = 1; swe = 1; addr = 16'hFFF0; cycle("R2 set before reset");
    rst_n = 0; #1;
    chk("R1 async clear flag", err_flag, 1'b0);
    model_flag = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // Random mix around the boundary
    for (int i = 0; i < 400; i++) begin
      lock   = 16'($urandom_range(16, 16'hFFF0));
      addr   = 16'(int'(lock) + $urandom_range(0, 4) - 2);
      wr     = 1'($urandom); swe = 1'($urandom);
      rd     = ($urandom % 3) == 0; ft = ($urandom % 3) == 0;
      mon_on = ($urandom % 5) != 0; mon_hi = ($urandom % 5) != 0;
      sec    = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      oth    = ($urandom % 4) == 0;
      cycle("RAND R2 R3 R4 R5 R7 R11");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule